// File: doc/BRIEF.md
# Texture Sampling Unit

This unit turns one 2D texture lookup into memory reads and a single texel result. A request carries two fixed-point coordinates with 16 integer bits and 8 fractional bits. Each coordinate is either in texel units or scaled by the texture size, so that 0 to 1 spans the whole texture. An out-of-range coordinate is either wrapped around the texture or held at its edge. The unit then forms the linear addresses of the texel or texels it needs and reads them one per cycle through a single-port memory interface with one cycle of read latency. It returns either the nearest texel or a bilinear blend of four neighbours.

The texture width and height are powers of two, given as log2 configuration inputs, and the texture's first texel sits at a configurable base address. A separate raw mode treats the first coordinate field as a plain integer element index. In that mode no scaling, filtering or edge handling is applied. Requests and results use valid/ready handshakes, and only one lookup is in progress at a time.

Top module: `tex_sampler`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_en is 0. req_ready is 1 only while no lookup is in progress and no result is waiting. Once a request is accepted, req_ready stays 0 until that result has been taken.
- R2: A coordinate is unsigned 16.8 fixed point. With req_norm=0 the texel index is its integer part. With req_norm=1 the coordinate is first multiplied by the texture dimension on that axis (width for u, height for v), which is 2^cfg_wlog2 or 2^cfg_hlog2.
- R3: With req_wrap=1, every texel index is reduced modulo the dimension on its axis. This includes indices below zero: -1 becomes dimension-1.
- R4: With req_wrap=0, a texel index below zero becomes 0 and an index at or above the dimension becomes dimension-1.
- R5: With req_bilin=0, exactly one read is issued at the floor of the scaled coordinate on each axis, after R3/R4. rsp_data equals the texel read, unmodified.
- R6: With req_bilin=1, 128 (one half texel) is subtracted from each scaled coordinate. The floor gives neighbour 0 and floor+1 gives neighbour 1, and the low 8 bits give the weight f. The edge mode of R3/R4 is applied to each of the two neighbours on its own.
- R7: A bilinear lookup issues exactly four reads on consecutive cycles, in the order (x0,y0), (x1,y0), (x0,y1), (x1,y1).
- R8: The bilinear result is ((A*(256-fx)+B*fx)*(256-fy) + (C*(256-fx)+D*fx)*fy + 32768) >> 16, with A..D the four texels in read order. This rounds to nearest.
- R9: A texel address is (cfg_base + y*2^cfg_wlog2 + x) modulo 2^20.
- R10: With req_raw1d=1, one read is issued at (cfg_base + req_u) modulo 2^20 and the texel is returned unmodified. req_v, req_norm, req_bilin and req_wrap have no effect.
- R11: With cfg_hlog2=0 (one row), every y index is 0, so a bilinear lookup reads two texels twice and returns a linear blend along x rounded to nearest.
- R12: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 20 | Address of texel (0,0) |
| cfg_wlog2 | input | 4 | log2 of texture width |
| cfg_hlog2 | input | 4 | log2 of texture height |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when both are 1 |
| req_u | input | 24 | First coordinate, 16.8, or raw index |
| req_v | input | 24 | Second coordinate, 16.8 |
| req_norm | input | 1 | 1: coordinates scaled by texture size |
| req_bilin | input | 1 | 1: bilinear blend, 0: nearest texel |
| req_wrap | input | 1 | 1: wrap, 0: clamp to edge |
| req_raw1d | input | 1 | 1: raw integer index mode |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 20 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken when both are 1 |
| rsp_data | output | 16 | Sampled texel value |

## Verification
On every cycle the assertions check the handshake rules and the shape of the read burst. They confirm that no request is taken while reads or a result are pending, that a held result stays still, and that each lookup issues either one read or four back-to-back reads before its result appears. Which addresses are read, how wrap and clamp treat each neighbour, normalized scaling, the blend arithmetic and its rounding, and the raw index mode can only be shown by the bench's scenarios. Each scenario compares the logged read addresses and the returned value against values worked out from the coordinates.

// File: rtl/tex_pkg.sv
`timescale 1ns/1ps
package tex_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN,
    ST_FILT,
    ST_RESP
  } tex_state_e;
endpackage

// File: rtl/tex_axis_map.sv
`timescale 1ns/1ps
// One axis: scale, centre for filtering, split into index and weight,
// then fold both neighbour indices into range.
module tex_axis_map #(
  parameter int COORD_W = 24,
  parameter int FRAC_W  = 8,
  parameter int LOG_W   = 4,
  parameter int IDX_W   = 16
) (
  input  logic [COORD_W-1:0] coord,
  input  logic [LOG_W-1:0]   dim_log2,
  input  logic               norm,
  input  logic               filt,
  input  logic               wrap,
  output logic [IDX_W-1:0]   idx_lo,
  output logic [IDX_W-1:0]   idx_hi,
  output logic [FRAC_W-1:0]  frac
);
  localparam int EXT_W = COORD_W + (1 << LOG_W) + 2;
  localparam logic signed [EXT_W-1:0] HALF  = EXT_W'(1 << (FRAC_W - 1));
  localparam logic signed [EXT_W-1:0] ONE_E = EXT_W'(1);

  logic signed [EXT_W-1:0] base_c, scaled_c, cent_c, ipart, ipart_n;
  logic [IDX_W-1:0]        dim_m1;

  function automatic logic [IDX_W-1:0] fold(
    input logic signed [EXT_W-1:0] i,
    input logic                    wr,
    input logic [IDX_W-1:0]        lim
  );
    if (wr)
      fold = i[IDX_W-1:0] & lim;
    else if (i[EXT_W-1])
      fold = '0;
    else if (i > $signed({{(EXT_W-IDX_W){1'b0}}, lim}))
      fold = lim;
    else
      fold = i[IDX_W-1:0];
  endfunction

  always_comb begin
    base_c   = $signed({{(EXT_W-COORD_W){1'b0}}, coord});
    scaled_c = norm ? (base_c <<< dim_log2) : base_c;
    cent_c   = filt ? (scaled_c - HALF) : scaled_c;
    ipart    = cent_c >>> FRAC_W;
    ipart_n  = ipart + ONE_E;
    frac     = filt ? cent_c[FRAC_W-1:0] : '0;
    dim_m1   = ~({IDX_W{1'b1}} << dim_log2);
    idx_lo   = fold(ipart, wrap, dim_m1);
    idx_hi   = fold(ipart_n, wrap, dim_m1);
  end
endmodule

// File: rtl/tex_bilerp.sv
`timescale 1ns/1ps
// Two horizontal blends, one vertical blend, round to nearest.
module tex_bilerp #(
  parameter int TEXEL_W = 16,
  parameter int FRAC_W  = 8
) (
  input  logic [TEXEL_W-1:0] t00,
  input  logic [TEXEL_W-1:0] t10,
  input  logic [TEXEL_W-1:0] t01,
  input  logic [TEXEL_W-1:0] t11,
  input  logic [FRAC_W-1:0]  fx,
  input  logic [FRAC_W-1:0]  fy,
  output logic [TEXEL_W-1:0] result
);
  localparam int W_W  = FRAC_W + 1;
  localparam int TW   = TEXEL_W + FRAC_W + 1;
  localparam int SW   = TEXEL_W + 2 * FRAC_W + 2;
  localparam logic [W_W-1:0] UNIT = W_W'(1 << FRAC_W);
  localparam logic [SW-1:0]  RND  = SW'(1) << (2 * FRAC_W - 1);

  logic [W_W-1:0] wx_inv, wy_inv;
  logic [TW-1:0]  row_a, row_b;
  logic [SW-1:0]  acc;

  always_comb begin
    wx_inv = UNIT - W_W'(fx);
    wy_inv = UNIT - W_W'(fy);
    row_a  = TW'(t00) * TW'(wx_inv) + TW'(t10) * TW'(fx);
    row_b  = TW'(t01) * TW'(wx_inv) + TW'(t11) * TW'(fx);
    acc    = SW'(row_a) * SW'(wy_inv) + SW'(row_b) * SW'(fy) + RND;
    result = TEXEL_W'(acc >> (2 * FRAC_W));
  end
endmodule

// File: rtl/tex_sampler.sv
`timescale 1ns/1ps
module tex_sampler #(
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 24,
  parameter int FRAC_W  = 8,
  parameter int TEXEL_W = 16,
  parameter int LOG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LOG_W-1:0]   cfg_wlog2,
  input  logic [LOG_W-1:0]   cfg_hlog2,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_u,
  input  logic [COORD_W-1:0] req_v,
  input  logic               req_norm,
  input  logic               req_bilin,
  input  logic               req_wrap,
  input  logic               req_raw1d,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [TEXEL_W-1:0] mem_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [TEXEL_W-1:0] rsp_data
);
  import tex_pkg::*;

  localparam int NTAP  = 4;
  localparam int TAP_W = $clog2(NTAP);
  localparam int IDX_W = COORD_W - FRAC_W;
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAP - 1);

  // ---------------- coordinate mapping, one instance per axis
  logic [COORD_W-1:0] ax_coord [2];
  logic [LOG_W-1:0]   ax_log   [2];
  logic [IDX_W-1:0]   ax_lo    [2];
  logic [IDX_W-1:0]   ax_hi    [2];
  logic [FRAC_W-1:0]  ax_frac  [2];
  logic               use_filt;

  assign ax_coord[0] = req_u;
  assign ax_coord[1] = req_v;
  assign ax_log[0]   = cfg_wlog2;
  assign ax_log[1]   = cfg_hlog2;
  assign use_filt    = req_bilin & ~req_raw1d;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_axis
      tex_axis_map #(
        .COORD_W(COORD_W), .FRAC_W(FRAC_W), .LOG_W(LOG_W), .IDX_W(IDX_W)
      ) i_map (
        .coord   (ax_coord[g]),
        .dim_log2(ax_log[g]),
        .norm    (req_norm),
        .filt    (use_filt),
        .wrap    (req_wrap),
        .idx_lo  (ax_lo[g]),
        .idx_hi  (ax_hi[g]),
        .frac    (ax_frac[g])
      );
    end
  endgenerate

  // ---------------- request-side address formation
  function automatic logic [ADDR_W-1:0] texel_addr(
    input logic [ADDR_W-1:0] base,
    input logic [LOG_W-1:0]  wlog,
    input logic [IDX_W-1:0]  x,
    input logic [IDX_W-1:0]  y
  );
    texel_addr = base + (ADDR_W'(y) << wlog) + ADDR_W'(x);
  endfunction

  logic [ADDR_W-1:0] req_addr [NTAP];

  always_comb begin
    for (int n = 0; n < NTAP; n++) begin
      req_addr[n] = texel_addr(cfg_base, cfg_wlog2,
                               n[0] ? ax_hi[0] : ax_lo[0],
                               n[1] ? ax_hi[1] : ax_lo[1]);
    end
    if (req_raw1d)
      req_addr[0] = cfg_base + ADDR_W'(req_u);
  end

  // ---------------- state
  tex_state_e        state_q, state_d;
  logic [TAP_W-1:0]  k_q, k_d;
  logic              pend_q;
  logic [TAP_W-1:0]  pend_idx_q;
  logic [ADDR_W-1:0] addr_q  [NTAP];
  logic [TEXEL_W-1:0] texel_q [NTAP];
  logic [FRAC_W-1:0] fx_q, fy_q;
  logic              single_q;
  logic [TEXEL_W-1:0] res_q;
  logic [TEXEL_W-1:0] blend;
  logic              ld_req, res_en;

  // ---------------- next-state logic
  always_comb begin
    state_d   = state_q;
    k_d       = k_q;
    req_ready = 1'b0;
    mem_rd_en = 1'b0;
    rsp_valid = 1'b0;
    ld_req    = 1'b0;
    res_en    = 1'b0;
    mem_addr  = addr_q[k_q];
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          ld_req  = 1'b1;
          k_d     = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_rd_en = 1'b1;
        if (single_q || k_q == LAST_TAP)
          state_d = ST_DRAIN;
        else
          k_d = k_q + TAP_W'(1);
      end
      ST_DRAIN: state_d = ST_FILT;
      ST_FILT: begin
        res_en  = 1'b1;
        state_d = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        if (rsp_ready)
          state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      k_q        <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      state_q    <= state_d;
      k_q        <= k_d;
      pend_q     <= mem_rd_en;
      pend_idx_q <= k_q;
    end
  end

  // ---------------- datapath registers, enabled, no reset
  always_ff @(posedge clk) begin
    if (ld_req) begin
      for (int n = 0; n < NTAP; n++) addr_q[n] <= req_addr[n];
      fx_q     <= ax_frac[0];
      fy_q     <= ax_frac[1];
      single_q <= ~use_filt;
    end
    if (pend_q)
      texel_q[pend_idx_q] <= mem_rdata;
    if (res_en)
      res_q <= single_q ? texel_q[0] : blend;
  end

  tex_bilerp #(.TEXEL_W(TEXEL_W), .FRAC_W(FRAC_W)) i_lerp (
    .t00   (texel_q[0]),
    .t10   (texel_q[1]),
    .t01   (texel_q[2]),
    .t11   (texel_q[3]),
    .fx    (fx_q),
    .fy    (fy_q),
    .result(blend)
  );

  assign rsp_data = res_q;
endmodule

// File: rtl/tex_sampler_chk.sv
`timescale 1ns/1ps
module tex_sampler_chk #(
  parameter int TEXEL_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               mem_rd_en,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [TEXEL_W-1:0] rsp_data
);
  // reads issued since the last accepted request
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (req_valid && req_ready)
      run_q <= '0;
    else if (mem_rd_en && run_q != 3'd7)
      run_q <= run_q + 3'd1;
  end

  // R1: nothing is accepted while reads or a result are outstanding
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || rsp_valid) |-> !req_ready);

  // R1: accepting a request closes the request port
  a_r1_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R12: a held result keeps its value
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5, R7: a burst ends after one read or four reads
  a_r7_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd_en) && !mem_rd_en) |-> (run_q == 3'd1 || run_q == 3'd4));

  // R7: reads of one lookup are on consecutive cycles
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && run_q != 3'd0) |-> $past(mem_rd_en));

  // R5: a result appears only after its reads
  a_r5_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (run_q != 3'd0));
endmodule

bind tex_sampler tex_sampler_chk #(.TEXEL_W(TEXEL_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .mem_rd_en(mem_rd_en),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data)
);

// File: tb/test_tex_sampler.sv
`timescale 1ns/1ps
module test_tex_sampler;
  logic        clk;
  logic        rst_n;
  logic [19:0] cfg_base;
  logic [3:0]  cfg_wlog2, cfg_hlog2;
  logic        req_valid, req_ready;
  logic [23:0] req_u, req_v;
  logic        req_norm, req_bilin, req_wrap, req_raw1d;
  logic        mem_rd_en;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        rsp_valid, rsp_ready;
  logic [15:0] rsp_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [19:0] log_addr [8];
  int          log_cyc  [8];
  int          nlog = 0;

  tex_sampler i_tex_sampler (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_wlog2(cfg_wlog2),
    .cfg_hlog2(cfg_hlog2), .req_valid(req_valid), .req_ready(req_ready),
    .req_u(req_u), .req_v(req_v), .req_norm(req_norm), .req_bilin(req_bilin),
    .req_wrap(req_wrap), .req_raw1d(req_raw1d), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [19:0] a);
    logic [35:0] p;
    p = 36'(a) * 36'd40503;
    return p[15:0] ^ 16'(a >> 4);
  endfunction

  // memory with one cycle of read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= memf(mem_addr);
  end

  // read logger, sampled mid-cycle
  always @(negedge clk) begin
    if (mem_rd_en && nlog < 8) begin
      log_addr[nlog] = mem_addr;
      log_cyc[nlog]  = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent model of the requirements
  function automatic longint fold(input longint i, input int dlog, input bit wr);
    longint dim = longint'(1) << dlog;
    if (wr) return i & (dim - 1);
    if (i < 0) return 0;
    if (i >= dim) return dim - 1;
    return i;
  endfunction

  task automatic model(input logic [23:0] u, input logic [23:0] v, input bit nm,
                       input bit bl, input bit wr, input bit raw,
                       output logic [19:0] ea [4], output int n, output logic [15:0] ed);
    longint tx, ty, x0, y0, x1, y1, fx, fy, a, b, c, d, s;
    if (raw) begin
      ea[0] = 20'((longint'(cfg_base) + longint'(u)) & 20'hFFFFF);
      n = 1;
      ed = memf(ea[0]);
      return;
    end
    tx = nm ? (longint'(u) << cfg_wlog2) : longint'(u);
    ty = nm ? (longint'(v) << cfg_hlog2) : longint'(v);
    if (bl) begin tx -= 128; ty -= 128; end
    x0 = fold(tx >>> 8, cfg_wlog2, wr);
    x1 = fold((tx >>> 8) + 1, cfg_wlog2, wr);
    y0 = fold(ty >>> 8, cfg_hlog2, wr);
    y1 = fold((ty >>> 8) + 1, cfg_hlog2, wr);
    fx = tx & 255; fy = ty & 255;
    ea[0] = 20'((longint'(cfg_base) + (y0 << cfg_wlog2) + x0) & 20'hFFFFF);
    ea[1] = 20'((longint'(cfg_base) + (y0 << cfg_wlog2) + x1) & 20'hFFFFF);
    ea[2] = 20'((longint'(cfg_base) + (y1 << cfg_wlog2) + x0) & 20'hFFFFF);
    ea[3] = 20'((longint'(cfg_base) + (y1 << cfg_wlog2) + x1) & 20'hFFFFF);
    if (!bl) begin
      n = 1;
      ed = memf(ea[0]);
    end else begin
      n = 4;
      a = memf(ea[0]); b = memf(ea[1]); c = memf(ea[2]); d = memf(ea[3]);
      s = (a * (256 - fx) + b * fx) * (256 - fy) + (c * (256 - fx) + d * fx) * fy + 32768;
      ed = 16'(s >> 16);
    end
  endtask

  // issue one request and collect its result
  task automatic run_fetch(input logic [23:0] u, input logic [23:0] v, input bit nm,
                           input bit bl, input bit wr, input bit raw,
                           output logic [15:0] got);
    int wait_n = 0;
    @(negedge clk);
    nlog = 0;
    req_u = u; req_v = v; req_norm = nm; req_bilin = bl; req_wrap = wr; req_raw1d = raw;
    req_valid = 1'b1;
    while (!req_ready && wait_n < 50) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && wait_n < 100) begin @(negedge clk); wait_n++; end
    got = rsp_data;
    if (rsp_ready) @(negedge clk);
  endtask

  task automatic full_check(input string tag, input logic [23:0] u, input logic [23:0] v,
                            input bit nm, input bit bl, input bit wr, input bit raw);
    logic [19:0] ea [4];
    int n;
    logic [15:0] ed, got;
    model(u, v, nm, bl, wr, raw, ea, n, ed);
    run_fetch(u, v, nm, bl, wr, raw, got);
    chk(nlog == n, {tag, " read count"}, nlog, n);
    for (int i = 0; i < n && i < nlog; i++) begin
      chk(log_addr[i] == ea[i], {tag, " read address"}, log_addr[i], ea[i]);
      if (i > 0) chk(log_cyc[i] == log_cyc[i-1] + 1, {tag, " R7 consecutive"}, log_cyc[i], log_cyc[i-1] + 1);
    end
    chk(got == ed, {tag, " result"}, got, ed);
  endtask

  task automatic t_reset();
    // R1: idle state after reset
    chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
    chk(mem_rd_en == 1'b0, "R1 reset mem_rd_en", mem_rd_en, 0);
  endtask

  task automatic t_point_texel();
    logic [15:0] got;
    // R2 R5 R9: u=5.75 v=3.25 -> x=5 y=3 -> base+0x35
    run_fetch(24'd1472, 24'd832, 0, 0, 1, 0, got);
    chk(nlog == 1, "R5 point one read", nlog, 1);
    chk(log_addr[0] == 20'h01035, "R9 point address", log_addr[0], 20'h01035);
    chk(got == memf(20'h01035), "R5 point data", got, memf(20'h01035));
  endtask

  task automatic t_point_wrap();
    logic [15:0] got;
    // R3: u=18.04 -> x=2, v=25.0 -> y=1 (height 8)
    run_fetch(24'd4618, 24'd6400, 0, 0, 1, 0, got);
    chk(log_addr[0] == 20'h01012, "R3 wrap address", log_addr[0], 20'h01012);
    chk(got == memf(20'h01012), "R3 wrap data", got, memf(20'h01012));
  endtask

  task automatic t_point_clamp();
    logic [15:0] got;
    // R4: same coordinates, clamped to x=15 y=7
    run_fetch(24'd4618, 24'd6400, 0, 0, 0, 0, got);
    chk(log_addr[0] == 20'h0107F, "R4 clamp address", log_addr[0], 20'h0107F);
  endtask

  task automatic t_norm();
    logic [15:0] got;
    // R2: u=0.5 of width 16 -> x=8, v=0.75 of height 8 -> y=6
    run_fetch(24'd128, 24'd192, 1, 0, 1, 0, got);
    chk(log_addr[0] == 20'h01068, "R2 normalized address", log_addr[0], 20'h01068);
    full_check("R2 normalized bilinear", 24'd100, 24'd77, 1, 1, 0, 0);
  endtask

  task automatic t_bilinear();
    // R6 R7 R8: interior, fx=64 fy=192, reads 0x1025 0x1026 0x1035 0x1036
    full_check("R8 interior", 24'd1472, 24'd832, 0, 1, 1, 0);
    chk(log_addr[1] == 20'h01026 && log_addr[2] == 20'h01035, "R7 order", log_addr[2], 20'h01035);
    full_check("R8 other weights", 24'd2305, 24'd1163, 0, 1, 0, 0);
  endtask

  task automatic t_edges();
    // R4 R6: x0=-1 clamps to 0, y1=8 clamps to 7
    full_check("R4 bilinear clamp edge", 24'd64, 24'd1984, 0, 1, 0, 0);
    chk(log_addr[0] == 20'h01070 && log_addr[3] == 20'h01070, "R4 clamp corner", log_addr[3], 20'h01070);
    // R3 R6: x0=-1 wraps to 15, y1=8 wraps to 0
    full_check("R3 bilinear wrap edge", 24'd64, 24'd1984, 0, 1, 1, 0);
    chk(log_addr[0] == 20'h0107F && log_addr[3] == 20'h01000, "R3 wrap corners", log_addr[3], 20'h01000);
  endtask

  task automatic t_raw();
    logic [15:0] got;
    // R10: filter, wrap and norm set but ignored
    run_fetch(24'h00ABCD, 24'h123456, 1, 1, 1, 1, got);
    chk(nlog == 1, "R10 raw one read", nlog, 1);
    chk(log_addr[0] == 20'h0BBCD, "R10 raw address", log_addr[0], 20'h0BBCD);
    chk(got == memf(20'h0BBCD), "R10 raw data", got, memf(20'h0BBCD));
  endtask

  task automatic t_one_row();
    logic [15:0] got;
    longint a, b, e;
    // R11: height 1, u=5.75 -> x0=5 x1=6 fx=64
    cfg_hlog2 = 4'd0;
    run_fetch(24'd1472, 24'd900, 0, 1, 0, 0, got);
    a = memf(20'h01005); b = memf(20'h01006);
    e = (a * 192 + b * 64 + 128) >> 8;
    chk(nlog == 4 && log_addr[2] == 20'h01005 && log_addr[3] == 20'h01006, "R11 one row reads", log_addr[3], 20'h01006);
    chk(got == 16'(e), "R11 linear result", got, e);
    cfg_hlog2 = 4'd3;
  endtask

  task automatic t_base_wrap();
    logic [15:0] got;
    // R9: address modulo 2^20
    cfg_base = 20'hFFFF0;
    run_fetch(24'd1472, 24'd832, 0, 0, 1, 0, got);
    chk(log_addr[0] == 20'h00025, "R9 address wraps", log_addr[0], 20'h00025);
    cfg_base = 20'h01000;
  endtask

  task automatic t_backpressure();
    logic [15:0] first, got;
    rsp_ready = 1'b0;
    run_fetch(24'd2305, 24'd1163, 0, 1, 1, 0, first);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R12 valid held", rsp_valid, 1);
      chk(rsp_data == first, "R12 data held", rsp_data, first);
      chk(req_ready == 1'b0, "R1 busy while result waits", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 released", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 ready again", req_ready, 1);
    got = first;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_base = 20'h01000; cfg_wlog2 = 4'd4; cfg_hlog2 = 4'd3;
    req_valid = 1'b0; req_u = '0; req_v = '0;
    req_norm = 1'b0; req_bilin = 1'b0; req_wrap = 1'b0; req_raw1d = 1'b0;
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_point_texel();
    t_point_wrap();
    t_point_clamp();
    t_norm();
    t_bilinear();
    t_edges();
    t_raw();
    t_one_row();
    t_base_wrap();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule